// File: doc/BRIEF.md
# External Bus Write Controller

This block runs the write cycle toward an external asynchronous memory or peripheral. It runs on a single internal bus clock. A requester offers an address and a data word together with a valid flag. The controller accepts the request only when it is idle. It then drives an active-low chip select, an active-low write strobe, the address bus, the data bus and a data output enable. When the access is over, it answers with a one-cycle done pulse.

The strobe can be lengthened in three ways, chosen per request:
- a programmed wait-state count;
- an external acknowledge line that stalls the access while it is low;
- the two together.

Once the acknowledge is seen high, the access always runs two more cycles before the strobe ends. A hold option keeps the data driven for one extra cycle after the strobe rises.

The strobe register is clocked on the falling edge of the bus clock. Chip select and address therefore lead the strobe by one and a half cycles, and the data enable follows the strobe by half a cycle on both edges.

Top module: `extbus_wr_ctrl`

## Requirements
- R1: During and after synchronous reset, `cs_n` and `wr_n` are high, `bus_data_oe` and `done` are low, and `req_ready` is high.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both high. `cs_n` goes low and `bus_addr` shows the request address from that edge on. `wr_n` falls at the falling edge one and a half cycles later.
- R3: Mode 0 uses wait states only. The strobe stays low for `cfg_waits`+1 cycles, so the minimum width is one cycle, and `ack_in` has no effect.
- R4: Mode 1 uses acknowledge only. The strobe is held for one cycle, ignoring `cfg_waits`. From then on `ack_in` is sampled at each rising edge, and every low sample extends the strobe by one cycle.
- R5: In any acknowledge mode, the strobe rises at the falling edge two cycles after the rising edge where `ack_in` is first sampled high. The total strobe width is base + stalls + 2 cycles.
- R6: Mode 2 combines both. The base phase is `cfg_waits`+1 cycles, and acknowledge sampling begins at its last rising edge.
- R7: `bus_data_oe` turns on at the first rising edge after `wr_n` falls. It turns off at the first rising edge after `wr_n` rises when `cfg_hold` is 0. While it is on, `bus_data` carries the request data.
- R8: With `cfg_hold` set to 1, `bus_data_oe`, `cs_n` and `done` are all delayed by exactly one more cycle.
- R9: `cs_n` rises together with a one-cycle `done` pulse and the data enable turning off. `bus_addr` stays stable while `cs_n` is low.
- R10: While an access is in progress, `req_ready` is low and `req_valid` is ignored, so no second access starts.
- R11: Mode value 3 behaves exactly like mode 2. The mode, wait count and hold option are captured when the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request offered |
| req_addr | input | ADDR_W | Request address |
| req_data | input | DATA_W | Request data |
| cfg_mode | input | 2 | 0 wait states, 1 acknowledge, 2 or 3 both |
| cfg_waits | input | WAIT_W | Wait-state count |
| cfg_hold | input | 1 | Extra data-hold cycle after the strobe |
| ack_in | input | 1 | External acknowledge; low stalls |
| req_ready | output | 1 | Controller idle, can accept |
| done | output | 1 | One-cycle pulse at end of access |
| cs_n | output | 1 | Chip select, active low |
| wr_n | output | 1 | Write strobe, active low, falling-edge timed |
| bus_addr | output | ADDR_W | Address bus |
| bus_data | output | DATA_W | Data bus value |
| bus_data_oe | output | 1 | Data bus output enable |

## Verification
A wrong sequencer state shows up at the ports within the same access. A miscounted wait or tail phase changes the number of cycles `wr_n` is low. A lost acknowledge sample either stalls the access until the watchdog expires or shortens the strobe. A bad recovery count moves the release of `cs_n` and the `done` pulse relative to the strobe edge. A stale capture register shows a wrong `bus_addr` or `bus_data` while chip select is low. Every access is measured by counting low samples of each control line. Each count is compared with the width predicted from mode, wait count, stall count and hold.

// File: rtl/ebw_pkg.sv
package ebw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_BASE,
    ST_ACKW,
    ST_TAIL,
    ST_RECOV
  } ebw_state_t;

  localparam int TAIL_CYCLES = 2;

  // mode 0: wait states only; 1: acknowledge only; 2 and 3: both
  function automatic logic mode_uses_waits(input logic [1:0] m);
    return (m != 2'd1);
  endfunction

  function automatic logic mode_uses_ack(input logic [1:0] m);
    return (m != 2'd0);
  endfunction

endpackage

// File: rtl/ebw_sequencer.sv
module ebw_sequencer
  import ebw_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        cfg_mode,
  input  logic [WAIT_W-1:0] cfg_waits,
  input  logic              cfg_hold,
  input  logic              ack_in,
  output logic              ready,
  output logic              accept,
  output logic              cs_active,
  output logic              strobe_req,
  output logic              oe_active,
  output logic              done
);

  localparam int CNT_W = (WAIT_W < 2) ? 2 : WAIT_W;

  ebw_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        mode_q;
  logic [WAIT_W-1:0] waits_q;
  logic              hold_q;

  assign ready  = (state == ST_IDLE);
  assign accept = ready && req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      mode_q     <= 2'd0;
      waits_q    <= '0;
      hold_q     <= 1'b0;
      cs_active  <= 1'b0;
      strobe_req <= 1'b0;
      oe_active  <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            mode_q    <= cfg_mode;
            waits_q   <= cfg_waits;
            hold_q    <= cfg_hold;
            cs_active <= 1'b1;
            state     <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          strobe_req <= 1'b1;
          cnt        <= mode_uses_waits(mode_q) ? CNT_W'(waits_q) : '0;
          state      <= ST_BASE;
        end
        ST_BASE: begin
          oe_active <= 1'b1;
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (mode_uses_ack(mode_q)) begin
            if (ack_in) begin
              cnt   <= CNT_W'(TAIL_CYCLES - 1);
              state <= ST_TAIL;
            end else begin
              state <= ST_ACKW;
            end
          end else begin
            strobe_req <= 1'b0;
            cnt        <= CNT_W'(hold_q);
            state      <= ST_RECOV;
          end
        end
        ST_ACKW: begin
          if (ack_in) begin
            cnt   <= CNT_W'(TAIL_CYCLES - 1);
            state <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            strobe_req <= 1'b0;
            cnt        <= CNT_W'(hold_q);
            state      <= ST_RECOV;
          end
        end
        ST_RECOV: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            cs_active <= 1'b0;
            oe_active <= 1'b0;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ACK_LOW_STALLS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACKW && !ack_in) |=> (state == ST_ACKW && strobe_req)); // R4

  AST_TAIL_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACKW && ack_in) |=> (state == ST_TAIL && strobe_req)); // R5

  AST_STROBE_ONLY_WITH_CS: assert property (@(posedge clk) disable iff (rst)
    strobe_req |-> cs_active); // R2

endmodule

// File: rtl/ebw_strobe_gen.sv
module ebw_strobe_gen #(
  parameter bit FALL_EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_req,
  output logic wr_n
);

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk) begin
        if (rst) wr_n <= 1'b1;
        else     wr_n <= ~strobe_req;
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) wr_n <= 1'b1;
        else     wr_n <= ~strobe_req;
      end
    end
  endgenerate

endmodule

// File: rtl/ebw_datapath.sv
module ebw_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      bus_data <= '0;
    end else if (accept) begin
      bus_addr <= req_addr;
      bus_data <= req_data;
    end
  end

endmodule

// File: rtl/extbus_wr_ctrl.sv
module extbus_wr_ctrl
  import ebw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [1:0]        cfg_mode,
  input  logic [WAIT_W-1:0] cfg_waits,
  input  logic              cfg_hold,
  input  logic              ack_in,
  output logic              req_ready,
  output logic              done,
  output logic              cs_n,
  output logic              wr_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_data_oe
);

  logic accept;
  logic cs_active;
  logic strobe_req;
  logic oe_active;

  ebw_sequencer #(.WAIT_W(WAIT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .cfg_mode   (cfg_mode),
    .cfg_waits  (cfg_waits),
    .cfg_hold   (cfg_hold),
    .ack_in     (ack_in),
    .ready      (req_ready),
    .accept     (accept),
    .cs_active  (cs_active),
    .strobe_req (strobe_req),
    .oe_active  (oe_active),
    .done       (done)
  );

  ebw_strobe_gen #(.FALL_EDGE(1'b1)) u_strobe (
    .clk        (clk),
    .rst        (rst),
    .strobe_req (strobe_req),
    .wr_n       (wr_n)
  );

  ebw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .req_addr (req_addr),
    .req_data (req_data),
    .bus_addr (bus_addr),
    .bus_data (bus_data)
  );

  assign cs_n        = ~cs_active;
  assign bus_data_oe = oe_active;

  AST_STROBE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> !cs_n); // R2

  AST_OE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
    bus_data_oe |-> !cs_n); // R7

  AST_OE_OFF_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_data_oe) |-> wr_n); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_CS_RELEASE_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> done); // R9

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$fell(cs_n)) |-> $stable(bus_addr)); // R9

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(req_ready && req_valid)); // R10

endmodule

// File: tb/extbus_wr_ctrl_test.sv
module extbus_wr_ctrl_test;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int WW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [1:0]    cfg_mode = 2'd0;
  logic [WW-1:0] cfg_waits = '0;
  logic          cfg_hold = 1'b0;
  logic          ack_in = 1'b0;
  logic          req_ready, done, cs_n, wr_n, bus_data_oe;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;

  always #10 clk = ~clk;

  extbus_wr_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .cfg_mode(cfg_mode), .cfg_waits(cfg_waits),
    .cfg_hold(cfg_hold), .ack_in(ack_in), .req_ready(req_ready),
    .done(done), .cs_n(cs_n), .wr_n(wr_n), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_data_oe(bus_data_oe)
  );

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int            slen;
    int            hold;
    int            id;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: predicts strobe width from mode, waits, stalls; pushes to scoreboard.
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [1:0] mode, input int w, input bit hold,
                          input int s, input bit poke_busy, input int id);
    int   b;
    int   l;
    exp_t e;
    b = (mode == 2'd1) ? 1 : w + 1;        // R4 R6 base phase
    l = (mode == 2'd0) ? b : b + s + 2;    // R3 R5 width
    e.a = a; e.d = d; e.slen = l; e.hold = int'(hold); e.id = id;
    sb.push_back(e);
    @(negedge clk);
    cfg_mode = mode; cfg_waits = WW'(w); cfg_hold = hold;
    req_addr = a; req_data = d; req_valid = 1'b1; ack_in = 1'b0;
    @(negedge clk);
    if (poke_busy) begin
      req_addr = ~a; req_data = ~d;
      for (int k = 0; k < 3; k++) begin
        chk(req_ready == 1'b0, "R10 ready low while busy", int'(req_ready), 0);
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    if (mode != 2'd0) begin
      @(negedge wr_n);
      for (int k = 0; k < b + s - 1; k++) @(negedge clk);
      ack_in = 1'b1;
    end
    @(posedge done);
    @(negedge clk);
    ack_in = 1'b0;
  endtask

  // Monitor: measures every access and compares with the scoreboard head.
  initial begin
    int   cs_c, wr_c, oe_c, cs_at_wr, idx, last_wr, last_oe;
    bit   active, bad_a, bad_d;
    exp_t e;
    cs_c = 0; wr_c = 0; oe_c = 0; cs_at_wr = 0; idx = 0; last_wr = 0; last_oe = 0;
    active = 1'b0; bad_a = 1'b0; bad_d = 1'b0;
    forever begin
      @(posedge clk);
      #5;
      if (rst) continue;
      idx++;
      if (!cs_n) begin
        if (!active) begin
          active = 1'b1;
          cs_c = 0; wr_c = 0; oe_c = 0; cs_at_wr = 0;
          bad_a = 1'b0; bad_d = 1'b0;
          if (sb.size() == 0) chk(1'b0, "R10 unexpected access", 1, 0);
        end
        cs_c++;
        if (sb.size() > 0 && bus_addr != sb[0].a) bad_a = 1'b1;
      end
      if (!wr_n) begin
        if (wr_c == 0) cs_at_wr = cs_c;
        wr_c++;
        last_wr = idx;
      end
      if (bus_data_oe) begin
        oe_c++;
        last_oe = idx;
        if (sb.size() > 0 && bus_data != sb[0].d) bad_d = 1'b1;
      end
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R9 done without request", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(wr_c == e.slen, $sformatf("R3/R4/R5/R6 strobe width test %0d", e.id), wr_c, e.slen);
          chk(cs_at_wr == 3, $sformatf("R2 strobe falls after cs test %0d", e.id), cs_at_wr, 3);
          chk(oe_c == e.slen + e.hold, $sformatf("R7 data enable width test %0d", e.id), oe_c, e.slen + e.hold);
          chk(last_oe - last_wr == e.hold, $sformatf("R8 data hold test %0d", e.id), last_oe - last_wr, e.hold);
          chk(cs_c == e.slen + e.hold + 2, $sformatf("R9 cs width test %0d", e.id), cs_c, e.slen + e.hold + 2);
          chk(cs_n && !bus_data_oe, $sformatf("R9 release with done test %0d", e.id), int'(cs_n), 1);
          chk(!bad_a, $sformatf("R2 address test %0d", e.id), int'(bad_a), 0);
          chk(!bad_d, $sformatf("R7 data value test %0d", e.id), int'(bad_d), 0);
        end
        active = 1'b0;
      end
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
    chk(wr_n == 1'b1, "R1 wr_n", int'(wr_n), 1);
    chk(bus_data_oe == 1'b0, "R1 data enable", int'(bus_data_oe), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);

    do_write(16'h1000, 16'hA5A5, 2'd0, 0, 1'b0, 0, 1'b0, 1); // R3 minimum width
    do_write(16'h1234, 16'h00FF, 2'd0, 3, 1'b1, 0, 1'b0, 2); // R3 ack ignored, R8
    do_write(16'h2000, 16'h5A5A, 2'd1, 5, 1'b0, 0, 1'b0, 3); // R4 waits ignored
    do_write(16'h2002, 16'hBEEF, 2'd1, 0, 1'b1, 4, 1'b0, 4); // R4 R5 stalls
    do_write(16'h3000, 16'hCAFE, 2'd2, 2, 1'b0, 1, 1'b0, 5); // R6
    do_write(16'h3004, 16'h1357, 2'd3, 1, 1'b0, 2, 1'b0, 6); // R11
    do_write(16'h4000, 16'h2468, 2'd0, 7, 1'b0, 0, 1'b1, 7); // R10
    do_write(16'hFFFF, 16'hFFFF, 2'd2, 7, 1'b1, 3, 1'b0, 8); // R6 R8

    repeat (6) @(negedge clk);
    chk(sb.size() == 0, "R9 all accesses completed", sb.size(), 0);
    chk(cs_n == 1'b1 && req_ready == 1'b1, "R10 idle after refused request", int'(cs_n), 1);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule